// File: doc/BRIEF.md
# Dual-Transceiver Boundary-Scan Data Register

This block is the 44-cell boundary-scan data register of a device made from two 9-bit bidirectional bus transceiver halves. It runs on the test clock and follows per-cycle strobes from the test-access-port controller: an asynchronous test-logic-reset, capture, shift, update, and an idle-refresh strobe. The idle-refresh strobe is raised while the controller sits in run-test/idle and the active instruction asks the register to reload. A select input from the instruction decoder chooses the capture source, either the pins or the core logic.

Each cycle, a small decoder turns the strobes into one named operation: HOLD, CAPTURE, SHIFT, UPDATE or IDLE_CAP. Its priority runs CAPTURE > SHIFT > UPDATE > IDLE_CAP > HOLD. The transitions are strobe-driven. Any state can move to any other on the next edge, and test-logic-reset forces the reset contents at once. The cells form one serial chain from `tdi` to `tdo`. A parallel update bank drives the test-mode pin values and the four port enables. The bank only changes on UPDATE.

Top module: `bsr_dual_xcvr`

## Requirements
- R1: The chain is exactly 44 cells long. A vector shifted in appears unchanged at `tdo`, bit 0 first, during the next 44 shifts.
- R2: On SHIFT, `tdi` enters cell 43 and every cell moves one place toward cell 0. `tdo` always shows cell 0.
- R3: Cell layout, from the top down:
  - 43 is the half-2 B enable, 42 the half-1 B enable, 41 the half-2 A enable and 40 the half-1 A enable.
  - 39 is `pin_dir[1]`, 38 is `pin_dir[0]`, 37 is `pin_en[1]` and 36 is `pin_en[0]`.
  - 35..18 mirror `pin_a[17:0]` and 17..0 mirror `pin_b[17:0]`. Half 1 pin k sits at index k-1 and half 2 pin k at index 8+k.
  - The update bank maps the same cells onto `tm_oe[3:0]`, `tm_dir`, `tm_en`, `tm_a` and `tm_b`.
- R4: While `tlr_n` is low, cells 43..40 and `tm_oe` are 0, so every port would be high impedance.
- R5: On a capture from the pins (`src_core`=0), the A-enable cell of half h takes `pin_en[h] & ~pin_dir[h]` and the B-enable cell takes `pin_en[h] & pin_dir[h]`.
- R6: On a capture from the pins, each shared bidirectional cell takes its pin value and cells 39..36 take the direction and enable pins.
- R7: On a capture from the core (`src_core`=1), the data cells take `core_a`/`core_b`, and cells 43..40 take `core_oe[3:0]` (bit 3 half-2 B, bit 2 half-1 B, bit 1 half-2 A, bit 0 half-1 A). Cells 39..36 still take the pins.
- R8: The update outputs change only on UPDATE, where they take the chain contents. Shifting and capturing leave them untouched.
- R9: IDLE_CAP reloads the chain from the source chosen by `src_core`, exactly as CAPTURE does.
- R10: HOLD leaves the chain unchanged whatever the pins do.
- R11: When capture and shift strobes coincide, the cycle performs CAPTURE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr_n | input | 1 | Test-logic-reset, active low, asynchronous |
| cap_dr | input | 1 | Capture strobe |
| shf_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| idle_cap | input | 1 | Reload request while in run-test/idle |
| src_core | input | 1 | Capture source: 1 core, 0 pins |
| tdi | input | 1 | Serial data in |
| pin_en | input | 2 | Per-half enable pins, 1 = enabled |
| pin_dir | input | 2 | Per-half direction pins, 1 = A to B |
| pin_a | input | 18 | A-port pin values |
| pin_b | input | 18 | B-port pin values |
| core_a | input | 18 | Core data toward the A port |
| core_b | input | 18 | Core data toward the B port |
| core_oe | input | 4 | Core-decoded port enables |
| tdo | output | 1 | Serial data out (cell 0) |
| tm_oe | output | 4 | Test-mode port drive enables |
| tm_dir | output | 2 | Test-mode direction values |
| tm_en | output | 2 | Test-mode enable values |
| tm_a | output | 18 | Test-mode A-port values |
| tm_b | output | 18 | Test-mode B-port values |

## Verification
Some behaviour is checked by properties on every cycle:
- the shift step at the chain ends;
- the enable-cell equations for both capture sources;
- the chain holding when no strobe is active;
- the update bank staying still outside UPDATE;
- the enable outputs being zero under reset.

Other behaviour only the bench's scenarios can show: the full 44-cell field layout seen serially, end-to-end round trips, the idle reload, the strobe priority and the enable values reaching the pins after update.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_CAPTURE  = 3'd1,
        OP_SHIFT    = 3'd2,
        OP_UPDATE   = 3'd3,
        OP_IDLE_CAP = 3'd4
    } bsr_op_e;

    localparam int unsigned N_OE  = 4;
    localparam int unsigned N_CTL = 4;

    function automatic int unsigned chain_len(input int unsigned half_w);
        return N_OE + N_CTL + 4 * half_w;
    endfunction

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
    import bsr_pkg::*;
(
    input  logic    cap_dr,
    input  logic    shf_dr,
    input  logic    upd_dr,
    input  logic    idle_cap,
    output bsr_op_e op
);

    // Strobe priority: capture, shift, update, idle reload, hold.
    always_comb begin
        if (cap_dr)        op = OP_CAPTURE;
        else if (shf_dr)   op = OP_SHIFT;
        else if (upd_dr)   op = OP_UPDATE;
        else if (idle_cap) op = OP_IDLE_CAP;
        else               op = OP_HOLD;
    end

endmodule

// File: rtl/bsr_capture_mux.sv
module bsr_capture_mux
    import bsr_pkg::*;
#(
    parameter int unsigned HALF_W = 9,
    localparam int unsigned PW  = 2 * HALF_W,
    localparam int unsigned LEN = N_OE + N_CTL + 2 * PW
) (
    input  logic              src_core,
    input  logic [1:0]        pin_en,
    input  logic [1:0]        pin_dir,
    input  logic [PW-1:0]     pin_a,
    input  logic [PW-1:0]     pin_b,
    input  logic [PW-1:0]     core_a,
    input  logic [PW-1:0]     core_b,
    input  logic [N_OE-1:0]   core_oe,
    output logic [LEN-1:0]    cap_vec
);

    logic [N_OE-1:0]  pin_oe;
    logic [N_CTL-1:0] ctl;

    // Enable cells derived from the per-half enable and direction pins.
    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            assign pin_oe[h]     = pin_en[h] & ~pin_dir[h]; // A side
            assign pin_oe[h + 2] = pin_en[h] &  pin_dir[h]; // B side
        end
    endgenerate

    assign ctl = {pin_dir, pin_en};

    always_comb begin
        if (src_core) cap_vec = {core_oe, ctl, core_a, core_b};
        else          cap_vec = {pin_oe,  ctl, pin_a,  pin_b};
    end

endmodule

// File: rtl/bsr_cell_chain.sv
module bsr_cell_chain
    import bsr_pkg::*;
#(
    parameter int unsigned LEN = 44
) (
    input  logic           tck,
    input  logic           tlr_n,
    input  bsr_op_e        op,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] stage
);

    genvar i;
    generate
        for (i = 0; i < LEN; i++) begin : g_cell
            logic ser_in;
            logic cell_q;

            if (i == LEN - 1) begin : g_head
                assign ser_in = tdi;
            end else begin : g_body
                assign ser_in = stage[i + 1];
            end

            always_ff @(posedge tck or negedge tlr_n) begin
                if (!tlr_n) begin
                    cell_q <= 1'b0;
                end else begin
                    unique case (op)
                        OP_CAPTURE, OP_IDLE_CAP: cell_q <= cap_vec[i];
                        OP_SHIFT:                cell_q <= ser_in;
                        OP_UPDATE, OP_HOLD:      cell_q <= cell_q;
                        default:                 cell_q <= cell_q;
                    endcase
                end
            end

            assign stage[i] = cell_q;
        end
    endgenerate

    p_hold_r10: assert property (@(posedge tck) disable iff (!tlr_n)
        (op == OP_HOLD || op == OP_UPDATE) |=> $stable(stage))
        else $error("p_hold_r10");

    p_shift_head_r2: assert property (@(posedge tck) disable iff (!tlr_n)
        (op == OP_SHIFT) |=> (stage[LEN-1] == $past(tdi)) && (stage[0] == $past(stage[1])))
        else $error("p_shift_head_r2");

endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank
    import bsr_pkg::*;
#(
    parameter int unsigned LEN = 44
) (
    input  logic           tck,
    input  logic           tlr_n,
    input  bsr_op_e        op,
    input  logic [LEN-1:0] stage,
    output logic [LEN-1:0] upd_q
);

    always_ff @(posedge tck or negedge tlr_n) begin
        if (!tlr_n)                upd_q <= '0;
        else if (op == OP_UPDATE)  upd_q <= stage;
    end

    p_upd_stable_r8: assert property (@(posedge tck) disable iff (!tlr_n)
        (op != OP_UPDATE) |=> $stable(upd_q))
        else $error("p_upd_stable_r8");

    always @(posedge tck) begin
        if (!tlr_n) begin
            p_reset_oe_r4: assert (upd_q[LEN-1 -: N_OE] == '0)
                else $error("p_reset_oe_r4");
        end
    end

endmodule

// File: rtl/bsr_dual_xcvr.sv
module bsr_dual_xcvr
    import bsr_pkg::*;
#(
    parameter int unsigned HALF_W = 9,
    localparam int unsigned PW  = 2 * HALF_W,
    localparam int unsigned LEN = N_OE + N_CTL + 2 * PW
) (
    input  logic              tck,
    input  logic              tlr_n,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  logic              upd_dr,
    input  logic              idle_cap,
    input  logic              src_core,
    input  logic              tdi,
    input  logic [1:0]        pin_en,
    input  logic [1:0]        pin_dir,
    input  logic [PW-1:0]     pin_a,
    input  logic [PW-1:0]     pin_b,
    input  logic [PW-1:0]     core_a,
    input  logic [PW-1:0]     core_b,
    input  logic [N_OE-1:0]   core_oe,
    output logic              tdo,
    output logic [N_OE-1:0]   tm_oe,
    output logic [1:0]        tm_dir,
    output logic [1:0]        tm_en,
    output logic [PW-1:0]     tm_a,
    output logic [PW-1:0]     tm_b
);

    bsr_op_e          op;
    logic [LEN-1:0]   cap_vec;
    logic [LEN-1:0]   stage;
    logic [LEN-1:0]   upd_q;

    bsr_op_decode u_dec (
        .cap_dr   (cap_dr),
        .shf_dr   (shf_dr),
        .upd_dr   (upd_dr),
        .idle_cap (idle_cap),
        .op       (op)
    );

    bsr_capture_mux #(.HALF_W(HALF_W)) u_mux (
        .src_core (src_core),
        .pin_en   (pin_en),
        .pin_dir  (pin_dir),
        .pin_a    (pin_a),
        .pin_b    (pin_b),
        .core_a   (core_a),
        .core_b   (core_b),
        .core_oe  (core_oe),
        .cap_vec  (cap_vec)
    );

    bsr_cell_chain #(.LEN(LEN)) u_chain (
        .tck     (tck),
        .tlr_n   (tlr_n),
        .op      (op),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .stage   (stage)
    );

    bsr_update_bank #(.LEN(LEN)) u_upd (
        .tck   (tck),
        .tlr_n (tlr_n),
        .op    (op),
        .stage (stage),
        .upd_q (upd_q)
    );

    assign tdo = stage[0];
    assign {tm_oe, tm_dir, tm_en, tm_a, tm_b} = upd_q;

    // Enable-cell equations checked at the chain against the pins (R5, R7).
    p_cap_pin_oe_r5: assert property (@(posedge tck) disable iff (!tlr_n)
        ((cap_dr || (!shf_dr && !upd_dr && idle_cap)) && !src_core) |=>
        (stage[LEN-1] == $past(pin_en[1] & pin_dir[1])) &&
        (stage[LEN-2] == $past(pin_en[0] & pin_dir[0])) &&
        (stage[LEN-3] == $past(pin_en[1] & ~pin_dir[1])) &&
        (stage[LEN-4] == $past(pin_en[0] & ~pin_dir[0])))
        else $error("p_cap_pin_oe_r5");

    p_cap_core_oe_r7: assert property (@(posedge tck) disable iff (!tlr_n)
        (cap_dr && src_core) |=> (stage[LEN-1 -: N_OE] == $past(core_oe)))
        else $error("p_cap_core_oe_r7");

endmodule

// File: tb/bsr_dual_xcvr_bench.sv
`timescale 1ns/1ps
module bsr_dual_xcvr_bench;

    localparam int LEN = 44;

    logic        tck = 1'b0;
    logic        tlr_n = 1'b0;
    logic        cap_dr = 0, shf_dr = 0, upd_dr = 0, idle_cap = 0, src_core = 0, tdi = 0;
    logic [1:0]  pin_en = 0, pin_dir = 0;
    logic [17:0] pin_a = 0, pin_b = 0, core_a = 0, core_b = 0;
    logic [3:0]  core_oe = 0;
    logic        tdo;
    logic [3:0]  tm_oe;
    logic [1:0]  tm_dir, tm_en;
    logic [17:0] tm_a, tm_b;

    int n_cmp = 0, n_bad = 0;

    bit    exp_q[$];
    bit    care_q[$];
    string req_q[$];
    int    idx_q[$];

    logic [LEN-1:0] model = '0;
    logic [LEN-1:0] care  = '0;
    logic [LEN-1:0] upd_model = '0;

    always #2.5 tck = ~tck;

    bsr_dual_xcvr u_bsr_dual_xcvr (
        .tck(tck), .tlr_n(tlr_n), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .idle_cap(idle_cap), .src_core(src_core), .tdi(tdi),
        .pin_en(pin_en), .pin_dir(pin_dir), .pin_a(pin_a), .pin_b(pin_b),
        .core_a(core_a), .core_b(core_b), .core_oe(core_oe),
        .tdo(tdo), .tm_oe(tm_oe), .tm_dir(tm_dir), .tm_en(tm_en), .tm_a(tm_a), .tm_b(tm_b)
    );

    function automatic logic [LEN-1:0] pin_vec();
        return {pin_en[1] & pin_dir[1], pin_en[0] & pin_dir[0],
                pin_en[1] & ~pin_dir[1], pin_en[0] & ~pin_dir[0],
                pin_dir, pin_en, pin_a, pin_b};
    endfunction

    function automatic logic [LEN-1:0] core_vec();
        return {core_oe, pin_dir, pin_en, core_a, core_b};
    endfunction

    // Monitor: pops one expected tdo bit per shift cycle.
    always @(negedge tck) begin
        if (tlr_n && shf_dr && !cap_dr && exp_q.size() > 0) begin
            bit e, c; string r; int k;
            e = exp_q.pop_front(); c = care_q.pop_front();
            r = req_q.pop_front(); k = idx_q.pop_front();
            if (c) begin
                n_cmp++;
                if (tdo !== e) begin
                    n_bad++;
                    $display("FAIL %s cell %0d: tdo actual %b expected %b", r, k, tdo, e);
                end
            end
        end
    end

    task automatic check(string req, logic [LEN-1:0] act, logic [LEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck); #1;
    endtask

    // Driver: shifts din in, pushing the expected outgoing cells.
    task automatic scan(logic [LEN-1:0] din, string req);
        for (int i = 0; i < LEN; i++) begin
            tdi = din[i]; shf_dr = 1;
            exp_q.push_back(model[i]); care_q.push_back(care[i]);
            req_q.push_back(req); idx_q.push_back(i);
            tick();
        end
        shf_dr = 0;
        model = din; care = '1;
    endtask

    task automatic capture(bit core);
        src_core = core; cap_dr = 1;
        model = core ? core_vec() : pin_vec(); care = '1;
        tick();
        cap_dr = 0;
    endtask

    task automatic update();
        upd_dr = 1; tick(); upd_dr = 0;
        upd_model = model;
    endtask

    function automatic logic [LEN-1:0] tm_all();
        return {tm_oe, tm_dir, tm_en, tm_a, tm_b};
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [LEN-1:0] pat;
        // R4: reset state
        repeat (3) @(posedge tck);
        #1;
        check("R4 tm_oe in reset", {40'd0, tm_oe}, '0);
        tlr_n = 1; tick();
        care = {4'hF, 40'd0};
        model = '0;
        scan(44'hA5_5A5A_5A5A, "R4 reset enable cells");

        // R2/R3/R5/R6: pin capture, half1 A->B enabled, half2 B->A enabled
        pin_en = 2'b11; pin_dir = 2'b01;
        pin_a = 18'h2A5C3; pin_b = 18'h15A3C;
        capture(0);
        pat = 44'h123_4567_89AB;
        scan(pat, "R3 R5 R6 pin capture layout");
        // R8: shifting left the update outputs alone
        check("R8 outputs held during shift", tm_all(), upd_model);
        update();
        check("R8 update loads chain", tm_all(), pat);

        // R5: every enable/direction combination
        for (int c = 0; c < 16; c++) begin
            pin_en = c[1:0]; pin_dir = c[3:2];
            pin_a = 18'(c * 4099); pin_b = ~18'(c * 777);
            capture(0);
            scan(44'(c) * 44'h1_0203_0405, "R5 enable equations");
        end

        // R7: core capture, pins must not reach data/enable cells
        pin_en = 2'b10; pin_dir = 2'b10;
        core_a = 18'h3F00F; core_b = 18'h00FF0; core_oe = 4'b1001;
        capture(1);
        check("R8 outputs held during capture", tm_all(), upd_model);
        scan(44'hFFF_FFFF_FFFF, "R7 core capture");
        update();
        check("R8 all-ones update", tm_all(), 44'hFFF_FFFF_FFFF);
        check("R4 tm_oe drive all ports", {40'd0, tm_oe}, 44'hF);

        // R1: round trip of a scanned-in vector
        scan(44'hC3C_3C3C_3C3C, "R1 load");
        scan(44'h0, "R1 round trip");

        // R9: idle reload from the pins
        pin_en = 2'b01; pin_dir = 2'b00; pin_a = 18'h1FFFF; pin_b = 18'h00001;
        src_core = 0; idle_cap = 1; model = pin_vec(); tick(); idle_cap = 0;
        scan(44'h0, "R9 idle reload pins");
        core_oe = 4'b0110;
        src_core = 1; idle_cap = 1; model = core_vec(); tick(); idle_cap = 0;
        scan(44'h0, "R9 idle reload core");

        // R10: hold while pins move
        capture(0);
        pat = model;
        pin_a = ~pin_a; pin_en = ~pin_en; pin_dir = ~pin_dir;
        repeat (5) tick();
        model = pat;
        scan(44'h0, "R10 hold");

        // R11: capture wins over shift
        pin_a = 18'h2AAAA; pin_b = 18'h15555;
        src_core = 0; cap_dr = 1; shf_dr = 1; tdi = 1;
        model = pin_vec(); tick();
        cap_dr = 0; shf_dr = 0;
        scan(44'h0, "R11 capture priority");

        // R4: reset in the middle of use
        scan('1, "R4 preload");
        update();
        tlr_n = 0; #1;
        check("R4 tm_oe cleared by reset", {40'd0, tm_oe}, '0);
        tick(); tlr_n = 1; tick();
        model = '0; care = {4'hF, 40'd0};
        scan(44'h0, "R4 enable cells after reset");

        tick(); tick();
        check("R1 scoreboard drained", 44'(exp_q.size()), '0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule